// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks and extends the chain of extended capability headers kept in a 4 KB device configuration space. The space is held in an external RAM with a 32-bit synchronous port. Each header word packs a capability identifier, a version nibble and the byte offset of the following header. The chain always begins at byte 256, and an all-zero word there means the chain is empty. The engine takes one command at a time and signals completion with a single-cycle `done` pulse.

A find command follows the chain until it meets the requested identifier or reaches the end. It returns the matching offset and the offset of the header in front of it. Identifier 0 is reserved, so searching for it yields offset 0 together with the tail of the chain. An add command first checks its arguments. It then links a new header onto the tail, or replaces the first header at byte 256 while keeping that header's link. Next it writes the new header word. Last, it sweeps the new capability's bytes through a byte-wide mask port, so that each byte becomes read-only and checked.

The walk stops with an error on a pointer outside the legal window and on a chain longer than a step budget. The step budget also catches a chain that loops back on itself.

Top module: `ecap_list_walker`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_rd`, `cfg_wr` and `msk_we` are low and `err_code` is 0.
- R2: A header word is laid out as identifier in bits 15:0, version in bits 19:16 and next byte offset in bits 31:20.
- R3: If the word at byte 256 is zero, a find returns `res_off` = 0 and `res_prev` = 0 with `err_code` 0.
- R4: A find whose identifier matches a header returns that header's byte offset in `res_off`. `res_prev` holds the previous header's offset, or 0 when the match is the first header.
- R5: A find without a match, and any find for identifier 0 on a chain with no zero-identifier header, returns `res_off` = 0 and `res_prev` = the offset of the last header.
- R6: A visited offset below 256, above 4088 or not a multiple of 4 ends the command with `err_code` 2 and results 0.
- R7: A command that would need more than MAX_STEPS header reads ends with `err_code` 3. This includes a chain that loops back on itself.
- R8: An add with offset below 256, offset not a multiple of 4, size below 8, or offset + size above 4096 ends with `err_code` 1 and makes no configuration or mask write.
- R9: An add at byte 256 rewrites the word there with the new identifier and version and keeps its existing next field. `res_prev` is 0.
- R10: An add elsewhere rewrites only bits 31:20 of the tail header, to the new offset. It then writes the new header with next = 0 and returns `res_off` = offset and `res_prev` = tail offset.
- R11: An add at an offset other than 256 on an empty chain ends with `err_code` 1 and makes no write.
- R12: After a successful add, exactly `size` mask writes occur, at byte addresses offset to offset + size − 1 in ascending order. Each carries write mask 0x00, write-1-clear mask 0x00 and check mask 0xFF.
- R13: A command is accepted only while `busy` is low. `cmd_valid` while busy has no effect. Each command gives exactly one `done` pulse, with `busy` low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_add | input | 1 | 1 = add, 0 = find |
| cmd_id | input | 16 | Capability identifier |
| cmd_ver | input | 4 | Version for add |
| cmd_off | input | 12 | Byte offset for add |
| cmd_size | input | 13 | Byte size for add |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 bad arguments, 2 bad pointer, 3 step budget |
| res_off | output | 12 | Found or added offset |
| res_prev | output | 12 | Previous header offset |
| cfg_rd | output | 1 | Configuration RAM read, data one cycle later |
| cfg_wr | output | 1 | Configuration RAM write |
| cfg_addr | output | 10 | Configuration RAM word address |
| cfg_wdata | output | 32 | Configuration RAM write data |
| cfg_rdata | input | 32 | Configuration RAM read data |
| msk_we | output | 1 | Mask RAM byte write |
| msk_addr | output | 12 | Mask RAM byte address |
| msk_wr_val | output | 8 | Write-enable mask value |
| msk_w1c_val | output | 8 | Write-1-clear mask value |
| msk_chk_val | output | 8 | Check mask value |

## Verification
Chains of every length from zero to one past the step budget are built, and each header in each chain is searched for, along with an absent identifier and identifier 0. This separates a first-header match, a mid-chain match, a tail located by exhaustion and a budget overrun that falls exactly on the final read. Single-header chains then point to 252, 258, 4088 and 4092, which separates the legal edge of the pointer window from the values just outside it. A sequence of adds at the base, elsewhere and at the top edge of the space shows whether link bits are preserved or rewritten, and illegal argument sets show that a rejected add leaves both RAMs untouched.

// File: rtl/ecap_pkg.sv
// Shared types for the extended capability list walker.
// Assumes a 4 KB configuration space and 32-bit header words.
package ecap_pkg;
    localparam int unsigned CFG_BYTES = 4096;
    localparam int unsigned OFF_W     = $clog2(CFG_BYTES);
    localparam int unsigned SIZE_W    = OFF_W + 1;
    localparam int unsigned WADDR_W   = OFF_W - 2;

    // Header word: link in the top bits, then version, then identifier.
    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [3:0]       ver;
        logic [15:0]      id;
    } ecap_hdr_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ARGS  = 2'd1,
        ERR_PTR   = 2'd2,
        ERR_STEPS = 2'd3
    } ecap_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_EVAL,
        ST_LINK,
        ST_HDR,
        ST_FILL
    } ecap_state_e;
endpackage

// File: rtl/ecap_ptr_check.sv
// Decides whether a header pointer may be visited.
// Legal pointers lie in [BASE, SPACE-HDR_BYTES] and are word aligned.
// Purely combinational; assumes BASE and SPACE fit in OFF_W+1 bits.
module ecap_ptr_check #(
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned BASE      = 256,
    parameter int unsigned SPACE     = 4096,
    parameter int unsigned HDR_BYTES = 8
) (
    input  logic [OFF_W-1:0] ptr,
    output logic             legal
);
    localparam logic [OFF_W:0] LO = (OFF_W+1)'(BASE);
    localparam logic [OFF_W:0] HI = (OFF_W+1)'(SPACE - HDR_BYTES);

    // Window and alignment test on the pointer.
    always_comb begin
        legal = ({1'b0, ptr} >= LO) && ({1'b0, ptr} <= HI) && (ptr[1:0] == 2'b00);
    end
endmodule

// File: rtl/ecap_step_limit.sv
// Counts header reads of one command and flags when the budget is used.
// Assumes the owner never requests a step while at_limit is high.
module ecap_step_limit #(
    parameter int unsigned MAX_STEPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned CNT_W = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_STEPS);

    logic [CNT_W-1:0] cnt;

    // Step counter, cleared at each new command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Budget reached flag.
    always_comb begin
        at_limit = (cnt == LIMIT);
    end

    // R7
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R7
    step_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);
endmodule

// File: rtl/ecap_mask_fill.sv
// Sweeps a byte range through the mask RAM port, one byte per cycle.
// A start pulse loads base and length; length must be nonzero and the
// sweep must be idle when start arrives.
module ecap_mask_fill #(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFF_W-1:0] base,
    input  logic [LEN_W-1:0] len,
    output logic             we,
    output logic [OFF_W-1:0] addr,
    output logic             last
);
    logic [LEN_W-1:0] remain;
    logic [OFF_W-1:0] ptr;

    // Byte pointer and remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            ptr    <= '0;
        end else if (start) begin
            remain <= len;
            ptr    <= base;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
            ptr    <= ptr + 1'b1;
        end
    end

    // Port drive from sweep state.
    always_comb begin
        we   = (remain != '0);
        addr = ptr;
        last = (remain == LEN_W'(1));
    end

    // R12
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we) |-> $past(start));

    // R12
    fill_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !we);
endmodule

// File: rtl/ecap_list_walker.sv
// Extended capability chain engine: find by identifier, or append and
// initialise a new capability. Reads the configuration RAM through a
// synchronous port with one cycle of read latency; writes whole words.
// Assumes callers keep capabilities from overlapping.
module ecap_list_walker
    import ecap_pkg::*;
#(
    parameter int unsigned MAX_STEPS = 1024,
    parameter int unsigned LIST_BASE = 256,
    parameter int unsigned MIN_SIZE  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_add,
    input  logic [15:0]        cmd_id,
    input  logic [3:0]         cmd_ver,
    input  logic [OFF_W-1:0]   cmd_off,
    input  logic [SIZE_W-1:0]  cmd_size,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err_code,
    output logic [OFF_W-1:0]   res_off,
    output logic [OFF_W-1:0]   res_prev,
    output logic               cfg_rd,
    output logic               cfg_wr,
    output logic [WADDR_W-1:0] cfg_addr,
    output logic [31:0]        cfg_wdata,
    input  logic [31:0]        cfg_rdata,
    output logic               msk_we,
    output logic [OFF_W-1:0]   msk_addr,
    output logic [7:0]         msk_wr_val,
    output logic [7:0]         msk_w1c_val,
    output logic [7:0]         msk_chk_val
);
    localparam logic [OFF_W-1:0]  BASE_OFF = OFF_W'(LIST_BASE);
    localparam logic [SIZE_W-1:0] SZ_MIN   = SIZE_W'(MIN_SIZE);
    localparam logic [SIZE_W:0]   SZ_SPACE = (SIZE_W+1)'(CFG_BYTES);

    ecap_state_e        state;
    logic               op_add_q;
    logic [15:0]        id_q;
    logic [3:0]         ver_q;
    logic [OFF_W-1:0]   off_q;
    logic [SIZE_W-1:0]  size_q;
    logic [OFF_W-1:0]   cur;
    logic [OFF_W-1:0]   prev;
    logic               first;
    logic [19:0]        tail_low;
    logic [OFF_W-1:0]   link_next;
    logic [OFF_W-1:0]   res_off_q;
    logic [OFF_W-1:0]   res_prev_q;
    ecap_err_e          err_q;
    logic               done_q;

    logic               args_ok;
    logic [SIZE_W:0]    end_sum;
    logic               ptr_ok;
    logic               at_limit;
    logic               accept;
    logic               fill_last;
    ecap_hdr_t          hdr;

    ecap_ptr_check #(
        .OFF_W(OFF_W), .BASE(LIST_BASE), .SPACE(CFG_BYTES), .HDR_BYTES(8)
    ) u_ptr (
        .ptr(cur), .legal(ptr_ok)
    );

    ecap_step_limit #(.MAX_STEPS(MAX_STEPS)) u_steps (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(cfg_rd), .at_limit(at_limit)
    );

    ecap_mask_fill #(.OFF_W(OFF_W), .LEN_W(SIZE_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(state == ST_HDR),
        .base(off_q), .len(size_q),
        .we(msk_we), .addr(msk_addr), .last(fill_last)
    );

    // Argument legality of an incoming add.
    always_comb begin
        end_sum = {2'b00, cmd_off} + {1'b0, cmd_size};
        args_ok = (cmd_off >= BASE_OFF) && (cmd_off[1:0] == 2'b00) &&
                  (cmd_size >= SZ_MIN) && (end_sum <= SZ_SPACE);
        accept  = (state == ST_IDLE) && cmd_valid;
        hdr     = ecap_hdr_t'(cfg_rdata);
    end

    // Command sequencing: walk, link, header write and mask sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_add_q   <= 1'b0;
            id_q       <= '0;
            ver_q      <= '0;
            off_q      <= '0;
            size_q     <= '0;
            cur        <= '0;
            prev       <= '0;
            first      <= 1'b0;
            tail_low   <= '0;
            link_next  <= '0;
            res_off_q  <= '0;
            res_prev_q <= '0;
            err_q      <= ERR_NONE;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_add_q   <= cmd_add;
                        id_q       <= cmd_id;
                        ver_q      <= cmd_ver;
                        off_q      <= cmd_off;
                        size_q     <= cmd_size;
                        cur        <= BASE_OFF;
                        prev       <= '0;
                        first      <= 1'b1;
                        res_off_q  <= '0;
                        res_prev_q <= '0;
                        if (cmd_add && !args_ok) begin
                            err_q  <= ERR_ARGS;
                            done_q <= 1'b1;
                        end else begin
                            err_q <= ERR_NONE;
                            state <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (!ptr_ok) begin
                        err_q  <= ERR_PTR;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (at_limit) begin
                        err_q  <= ERR_STEPS;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (first && (cfg_rdata == 32'h0)) begin
                        if (!op_add_q) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (off_q == BASE_OFF) begin
                            link_next <= '0;
                            res_off_q <= off_q;
                            state     <= ST_HDR;
                        end else begin
                            err_q  <= ERR_ARGS;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end else if (op_add_q && first && (off_q == BASE_OFF)) begin
                        link_next <= hdr.nxt;
                        res_off_q <= off_q;
                        state     <= ST_HDR;
                    end else if (!op_add_q && (hdr.id == id_q)) begin
                        res_off_q  <= cur;
                        res_prev_q <= prev;
                        done_q     <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (hdr.nxt == '0) begin
                        if (!op_add_q) begin
                            res_prev_q <= cur;
                            done_q     <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            tail_low   <= cfg_rdata[19:0];
                            link_next  <= '0;
                            res_off_q  <= off_q;
                            res_prev_q <= cur;
                            state      <= ST_LINK;
                        end
                    end else begin
                        prev  <= cur;
                        cur   <= hdr.nxt;
                        first <= 1'b0;
                        state <= ST_RD;
                    end
                end
                ST_LINK: state <= ST_HDR;
                ST_HDR:  state <= ST_FILL;
                ST_FILL: begin
                    if (fill_last) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive for the RAMs and the command result.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = done_q;
        err_code    = err_q;
        res_off     = res_off_q;
        res_prev    = res_prev_q;
        cfg_rd      = (state == ST_RD) && ptr_ok && !at_limit;
        cfg_wr      = (state == ST_LINK) || (state == ST_HDR);
        cfg_addr    = (state == ST_HDR) ? off_q[OFF_W-1:2] : cur[OFF_W-1:2];
        cfg_wdata   = (state == ST_LINK) ? {off_q, tail_low}
                                         : {link_next, ver_q, id_q};
        msk_wr_val  = 8'h00;
        msk_w1c_val = 8'h00;
        msk_chk_val = 8'hFF;
    end

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_rd, cfg_wr, msk_we}));

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R13
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable({op_add_q, id_q, off_q, size_q}));

    // R12
    mask_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |-> (msk_addr >= off_q) &&
                   ({2'b00, msk_addr} < ({2'b00, off_q} + {1'b0, size_q})));

    // R10
    write_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_wr || msk_we));

    // R10
    link_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK) |-> (cfg_wdata[19:0] == $past(cfg_rdata[19:0])));

    // R9
    base_next_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && off_q == BASE_OFF) |->
            (cfg_wdata[31:20] == $past(cfg_rdata[31:20])));
endmodule

// File: tb/sim_ecap_list_walker.sv
module sim_ecap_list_walker;
    localparam int STEPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_add = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done;
    logic [1:0]  err_code;
    logic [11:0] res_off, res_prev;
    logic        cfg_rd, cfg_wr;
    logic [9:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] rdq = 32'h0;
    logic        msk_we;
    logic [11:0] msk_addr;
    logic [7:0]  msk_wr_val, msk_w1c_val, msk_chk_val;

    logic [31:0] mem [0:1023];
    logic        pl_we = 1'b0, pl_clr = 1'b0;
    logic [9:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;

    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, mask_cnt = 0, mask_bad = 0, cfgwr_cnt = 0, mask_idx = 0;
    int exp_off = 0;
    logic prev_we = 1'b0;

    always #4 clk = ~clk;

    ecap_list_walker #(.MAX_STEPS(STEPS)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_add(cmd_add),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
        .busy(busy), .done(done), .err_code(err_code), .res_off(res_off),
        .res_prev(res_prev), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdq), .msk_we(msk_we), .msk_addr(msk_addr),
        .msk_wr_val(msk_wr_val), .msk_w1c_val(msk_w1c_val), .msk_chk_val(msk_chk_val)
    );

    // Configuration RAM model, one cycle read latency.
    always @(posedge clk) begin
        if (pl_clr) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
        end else if (pl_we) begin
            mem[pl_addr] <= pl_data;
        end else if (cfg_wr) begin
            mem[cfg_addr] <= cfg_wdata;
        end
        if (cfg_rd) rdq <= mem[cfg_addr];
    end

    // Port monitor between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (cfg_wr) cfgwr_cnt++;
            if (msk_we) begin
                if (!prev_we) mask_idx = 0;
                if (msk_addr != 12'(exp_off + mask_idx) || msk_wr_val != 8'h00 ||
                    msk_w1c_val != 8'h00 || msk_chk_val != 8'hFF) mask_bad++;
                mask_idx++;
                mask_cnt++;
            end
            prev_we = msk_we;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic poke(input int word, input logic [31:0] data);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = 10'(word); pl_data = data;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        pl_clr = 1'b1;
        @(negedge clk);
        pl_clr = 1'b0;
    endtask

    function automatic logic [31:0] hw(input int nxt, input int ver, input int id);
        return {12'(nxt), 4'(ver), 16'(id)};
    endfunction

    task automatic issue(input logic add, input int id, input int ver, input int off, input int size);
        exp_off = off;
        @(negedge clk);
        cmd_add = add; cmd_id = 16'(id); cmd_ver = 4'(ver);
        cmd_off = 12'(off); cmd_size = 13'(size); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk("R13", "command completion", int'(t < 20000), 1);
        @(negedge clk);
    endtask

    task automatic run(input logic add, input int id, input int ver, input int off, input int size);
        issue(add, id, ver, off, size);
        wait_done();
    endtask

    task automatic expect_res(input string req, input int e, input int o, input int p);
        chk(req, "err_code", int'(err_code), e);
        chk(req, "res_off", int'(res_off), o);
        chk(req, "res_prev", int'(res_prev), p);
    endtask

    initial begin
        #2000000;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        int d0, m0, w0, last;
        repeat (4) @(negedge clk);
        // R1: idle state right after reset release
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "strobes", int'({cfg_rd, cfg_wr, msk_we}), 0);
        chk("R1", "err_code", int'(err_code), 0);

        // R2 R3 R4 R5 R7: chains of length 0..STEPS+1, headers at 256+16k
        for (int n = 0; n <= STEPS + 1; n++) begin
            wipe();
            for (int k = 0; k < n; k++)
                poke(64 + 4 * k, hw((k < n - 1) ? 256 + 16 * (k + 1) : 0, k, 16'hA00 + k));
            last = (n == 0) ? 0 : 256 + 16 * (n - 1);
            for (int j = 0; j < n; j++) begin
                run(1'b0, 16'hA00 + j, 0, 0, 0);
                if (j < STEPS) expect_res("R4", 0, 256 + 16 * j, (j == 0) ? 0 : 256 + 16 * (j - 1));
                else           expect_res("R7", 3, 0, 0);
            end
            run(1'b0, 16'hBEEF, 0, 0, 0);
            if (n == 0)          expect_res("R3", 0, 0, 0);
            else if (n <= STEPS) expect_res("R5", 0, 0, last);
            else                 expect_res("R7", 3, 0, 0);
            run(1'b0, 0, 0, 0, 0);
            if (n <= STEPS) expect_res("R5", 0, 0, last);
            else            expect_res("R7", 3, 0, 0);
        end

        // R6: pointer window edges
        wipe();
        poke(64, hw(252, 1, 5));
        run(1'b0, 9, 0, 0, 0);
        expect_res("R6", 2, 0, 0);
        poke(64, hw(4092, 1, 5));
        run(1'b0, 9, 0, 0, 0);
        expect_res("R6", 2, 0, 0);
        poke(64, hw(258, 1, 5));
        run(1'b0, 9, 0, 0, 0);
        expect_res("R6", 2, 0, 0);
        poke(64, hw(4088, 1, 5));
        poke(1022, hw(0, 2, 16'h77));
        run(1'b0, 16'h77, 0, 0, 0);
        expect_res("R6", 0, 4088, 256);

        // R7: chain looping onto itself
        poke(64, hw(256, 1, 5));
        run(1'b0, 9, 0, 0, 0);
        expect_res("R7", 3, 0, 0);

        // R11: add off-base onto an empty chain
        wipe();
        w0 = cfgwr_cnt; m0 = mask_cnt;
        run(1'b1, 1, 1, 320, 8);
        expect_res("R11", 1, 0, 0);
        chk("R11", "config writes", cfgwr_cnt - w0, 0);
        chk("R11", "mask writes", mask_cnt - m0, 0);

        // R9 R12: first add at the base on an empty chain
        m0 = mask_cnt; w0 = cfgwr_cnt;
        run(1'b1, 1, 1, 256, 8);
        expect_res("R9", 0, 256, 0);
        chk("R9", "base header", int'(mem[64]), int'(32'h0001_0001));
        chk("R12", "mask count", mask_cnt - m0, 8);
        chk("R12", "mask order and values", mask_bad, 0);
        chk("R9", "config writes", cfgwr_cnt - w0, 1);

        // R10 R12: append elsewhere
        m0 = mask_cnt; w0 = cfgwr_cnt;
        run(1'b1, 2, 2, 320, 12);
        expect_res("R10", 0, 320, 256);
        chk("R10", "tail relinked", int'(mem[64]), int'(32'h1400_1001 + 32'h0001_0000 - 32'h0000_1000));
        chk("R10", "new header", int'(mem[80]), int'(32'h0002_0002));
        chk("R12", "mask count", mask_cnt - m0, 12);
        chk("R10", "config writes", cfgwr_cnt - w0, 2);

        // R9: base replacement keeps the link
        run(1'b1, 3, 3, 256, 8);
        expect_res("R9", 0, 256, 0);
        chk("R9", "link kept", int'(mem[64]), int'(32'h1403_0003));

        // R10 R8: top edge, offset+size exactly 4096
        m0 = mask_cnt;
        run(1'b1, 4, 5, 4088, 8);
        expect_res("R10", 0, 4088, 320);
        chk("R10", "tail relinked", int'(mem[80]), int'(32'hFF82_0002));
        chk("R10", "edge header", int'(mem[1022]), int'(32'h0005_0004));
        chk("R12", "mask count", mask_cnt - m0, 8);

        // R8: illegal argument sets
        for (int c = 0; c < 4; c++) begin
            int o, s;
            o = (c == 0) ? 252 : (c == 1) ? 258 : (c == 2) ? 512 : 4080;
            s = (c == 2) ? 7 : (c == 3) ? 24 : 8;
            w0 = cfgwr_cnt; m0 = mask_cnt;
            run(1'b1, 9, 1, o, s);
            expect_res("R8", 1, 0, 0);
            chk("R8", "config writes", cfgwr_cnt - w0, 0);
            chk("R8", "mask writes", mask_cnt - m0, 0);
        end

        // R13: strobe while busy is ignored
        d0 = done_cnt; m0 = mask_cnt;
        issue(1'b1, 4, 5, 512, 64);
        repeat (5) @(negedge clk);
        chk("R13", "busy during add", int'(busy), 1);
        cmd_add = 1'b0; cmd_id = 16'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk("R13", "done pulses", done_cnt - d0, 1);
        expect_res("R13", 0, 512, 4088);
        chk("R13", "tail relinked", int'(mem[1022]), int'(32'h2005_0004));
        chk("R12", "mask count", mask_cnt - m0, 64);
        chk("R12", "mask order and values", mask_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule